// File: doc/BRIEF.md
# Radix-16 Booth Multiply-Accumulate Slice with Shared Multiple Generation

This block is one slice of a convolution datapath. A single signed activation is broadcast to a row of weight lanes. Each lane multiplies that activation by its own signed weight and adds the product into a private accumulator. The activation is captured once in a register that all lanes share. The odd multiples 3x, 5x and 7x are formed once, next to that register, and every lane reads them. Convolution reuses each activation across many weights, so the cost of the hard multiples is paid once per slice and not once per lane.

Each lane splits its weight into signed radix-16 digits. A digit covers four weight bits and lies between -8 and +8. The digit selects one of the shared multiples, or a shift of one, and a negative digit inverts the selection. Each partial product is split into a low nibble and an upper part. The low parts and the upper parts go into two separate carry-save reduction trees. One correction word then accounts for all the sign bits and all the missing +1 terms of the inverted rows. It is added in the final addition, after both trees.

An upstream controller drives `in_valid_i` with one activation and one weight per lane. It pulses `clr_i` at the start of each new output pixel. It reads the accumulators once the stream for that pixel has drained.

Top module: `mac16_array`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted beat, every accumulator reads 0 and `out_valid_o` is 0.
- R2: All lanes in one beat use the activation of that beat. Lane `l` takes its weight from `wgt_i[l*WGT_W +: WGT_W]`, and lanes with different weights return independent, correct products.
- R3: Weights are recoded into WGT_W/4 radix-16 digits, with an implied 0 below bit 0. The extremes of the weight range give the products: -128 × -128 = 16384, 127 × -128 = -16256, and -1 × -128 = 128.
- R4: For every pair of 8-bit signed activation and weight, the value added to the accumulator equals their exact signed product.
- R5: Each accepted beat adds its product to the accumulator of its lane. Back-to-back beats are all summed, with no beat lost or counted twice.
- R6: A beat is accepted when `in_valid_i` is high at a rising edge (edge N). Its product is visible in `acc_o` after edge N+1. At that same edge N+1, `out_valid_o` goes high for one cycle for that beat.
- R7: `clr_i` high at a rising edge sets every accumulator to 0 at that edge. A product due at the same edge is dropped, and `out_valid_o` stays 0 for it.
- R8: When `in_valid_i` is low, the values on `act_i` and `wgt_i` have no effect. The accumulators keep their values, apart from a beat still in flight.
- R9: The accumulators wrap modulo 2^ACC_W as signed two's complement, with no saturation.
- R10: A zero activation or a zero weight adds exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat present on `act_i`/`wgt_i` |
| clr_i | input | 1 | Synchronous clear of all accumulators |
| act_i | input | ACT_W | Broadcast signed activation |
| wgt_i | input | LANES*WGT_W | Signed weights, lane 0 in the low bits |
| out_valid_o | output | 1 | One pulse per beat accumulated |
| acc_o | output | LANES*ACC_W | Signed accumulators, lane 0 in the low bits |

## Verification
The bench streams every activation value against every weight value, four lanes per beat. This catches a wrong window offset in the digit recoder, and a wrong shift for the 6x or 8x selection. Both show up only for certain bit patterns. The most negative operands and the 127 × -128 case are the points where a missing sign correction or a dropped +1 shows up as an error of one or of a power of two. A clear that lands on the same edge as a product in flight, and an accumulator driven past 2^23, check the priority of the clear and the wrap. A design that saturates, or lets the product slip through the clear, would read a different value. A single beat followed by idle cycles checks the two-edge latency and the valid pulse. Junk inputs driven while `in_valid_i` is low must leave every lane unchanged.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

    localparam int DIG_BITS = 4;

    typedef struct packed {
        logic       neg;
        logic [3:0] mag;
    } bdigit_t;

    // Radix-16 Booth digit from a 5-bit window {w[4i+3] .. w[4i-1]}.
    function automatic bdigit_t booth16_digit(input logic [4:0] win);
        bdigit_t    d;
        logic [3:0] pos;
        pos = {1'b0, win[3:1]} + {3'b000, win[0]};
        if (win[4] && (pos != 4'd8)) begin
            d.neg = 1'b1;
            d.mag = 4'd8 - pos;
        end else if (win[4]) begin
            d.neg = 1'b0;
            d.mag = 4'd0;
        end else begin
            d.neg = 1'b0;
            d.mag = pos;
        end
        return d;
    endfunction

endpackage

// File: rtl/mac16_precompute.sv
module mac16_precompute #(
    parameter int ACT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [ACT_W-1:0]     act_i,
    output logic [ACT_W+3:0]     m1_o,
    output logic [ACT_W+3:0]     m3_o,
    output logic [ACT_W+3:0]     m5_o,
    output logic [ACT_W+3:0]     m7_o
);
    localparam int MULT_W = ACT_W + 4;

    typedef struct packed {
        logic [MULT_W-1:0] m1;
        logic [MULT_W-1:0] m3;
        logic [MULT_W-1:0] m5;
        logic [MULT_W-1:0] m7;
    } mult_t;

    mult_t st_d, st_q;
    logic [MULT_W-1:0] x1;

    always_comb begin
        x1   = {{4{act_i[ACT_W-1]}}, act_i};
        st_d = st_q;
        if (load_i) begin
            st_d.m1 = x1;
            st_d.m3 = x1 + (x1 << 1);
            st_d.m5 = x1 + (x1 << 2);
            st_d.m7 = (x1 << 3) - x1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m1_o = st_q.m1;
    assign m3_o = st_q.m3;
    assign m5_o = st_q.m5;
    assign m7_o = st_q.m7;

    // R2: the shared odd multiples stay spaced by 2x of the activation
    a_r2_odd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.m5 - st_q.m3) == (st_q.m1 + st_q.m1)) &&
        ((st_q.m7 - st_q.m5) == (st_q.m1 + st_q.m1)));

endmodule

// File: rtl/mac16_wallace.sv
module mac16_wallace #(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic [W-1:0] rows_i [N],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] cur [N];
    logic [W-1:0] nxt [N];
    int cnt;
    int k;

    always_comb begin
        for (int r = 0; r < N; r++) cur[r] = rows_i[r];
        cnt = N;
        k   = 0;
        for (int lvl = 0; lvl < N; lvl++) begin
            if (cnt > 2) begin
                for (int r = 0; r < N; r++) nxt[r] = '0;
                k = 0;
                for (int g = 0; g < N; g += 3) begin
                    if (g + 2 < cnt) begin
                        nxt[k]     = cur[g] ^ cur[g+1] ^ cur[g+2];
                        nxt[k + 1] = ((cur[g] & cur[g+1]) | (cur[g] & cur[g+2]) |
                                      (cur[g+1] & cur[g+2])) << 1;
                        k = k + 2;
                    end else if (g < cnt) begin
                        nxt[k] = cur[g];
                        k = k + 1;
                        if (g + 1 < cnt) begin
                            nxt[k] = cur[g+1];
                            k = k + 1;
                        end
                    end
                end
                for (int r = 0; r < N; r++) cur[r] = nxt[r];
                cnt = k;
            end
        end
        sum_o   = cur[0];
        carry_o = (cnt > 1) ? cur[(N > 1) ? 1 : 0] : '0;
    end

endmodule

// File: rtl/mac16_lane.sv
module mac16_lane
    import mac16_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int WGT_W = 8,
    parameter int ACC_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [WGT_W-1:0]     wgt_i,
    input  logic                 valid_i,
    input  logic                 clr_i,
    input  logic [ACT_W+3:0]     m1_i,
    input  logic [ACT_W+3:0]     m3_i,
    input  logic [ACT_W+3:0]     m5_i,
    input  logic [ACT_W+3:0]     m7_i,
    output logic [ACC_W-1:0]     acc_o
);
    localparam int MULT_W = ACT_W + 4;
    localparam int NDIG   = WGT_W / DIG_BITS;
    localparam int PROD_W = ACT_W + WGT_W;

    typedef struct packed {
        logic [WGT_W-1:0] w;
        logic [ACC_W-1:0] acc;
    } lane_t;

    lane_t st_d, st_q;

    logic [WGT_W:0]      wext;
    bdigit_t             dig  [NDIG];
    logic [MULT_W-1:0]   sel  [NDIG];
    logic [MULT_W-1:0]   pp   [NDIG];
    logic [PROD_W-1:0]   lo_rows [NDIG];
    logic [PROD_W-1:0]   hi_rows [NDIG];
    logic [PROD_W-1:0]   lo_s, lo_c, hi_s, hi_c, corr, prod;

    always_comb begin
        wext = {st_q.w, 1'b0};
        corr = '0;
        for (int i = 0; i < NDIG; i++) begin
            dig[i] = booth16_digit(wext[4*i+4 -: 5]);
            case (dig[i].mag)
                4'd1:    sel[i] = m1_i;
                4'd2:    sel[i] = m1_i << 1;
                4'd3:    sel[i] = m3_i;
                4'd4:    sel[i] = m1_i << 2;
                4'd5:    sel[i] = m5_i;
                4'd6:    sel[i] = m3_i << 1;
                4'd7:    sel[i] = m7_i;
                4'd8:    sel[i] = m1_i << 3;
                default: sel[i] = '0;
            endcase
            pp[i]      = dig[i].neg ? ~sel[i] : sel[i];
            lo_rows[i] = PROD_W'(pp[i][3:0]) << (4*i);
            hi_rows[i] = PROD_W'({~pp[i][MULT_W-1], pp[i][MULT_W-2:4]}) << (4*i + 4);
            corr = corr + (PROD_W'(dig[i].neg) << (4*i))
                        - (PROD_W'(1) << (MULT_W - 1 + 4*i));
        end
    end

    mac16_wallace #(.N(NDIG), .W(PROD_W)) u_lo_tree (
        .rows_i (lo_rows),
        .sum_o  (lo_s),
        .carry_o(lo_c)
    );

    mac16_wallace #(.N(NDIG), .W(PROD_W)) u_hi_tree (
        .rows_i (hi_rows),
        .sum_o  (hi_s),
        .carry_o(hi_c)
    );

    always_comb begin
        prod = lo_s + lo_c + hi_s + hi_c + corr;
        st_d = st_q;
        if (load_i) st_d.w = wgt_i;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (valid_i) begin
            st_d.acc = st_q.acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // Independent reference product for the checker
    logic signed [PROD_W-1:0] chk_w, chk_a, chk_p;
    assign chk_w = {{(PROD_W-WGT_W){st_q.w[WGT_W-1]}}, st_q.w};
    assign chk_a = {{(PROD_W-MULT_W){m1_i[MULT_W-1]}}, m1_i};
    assign chk_p = chk_w * chk_a;

    // R4: compressed and corrected product equals the signed product
    a_r4_product_exact: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (prod == chk_p));

    // R7: clear forces the accumulator to zero at the next edge
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.acc == '0));

    // R8: without a beat in flight the accumulator holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clr_i) |=> $stable(st_q.acc));

endmodule

// File: rtl/mac16_array.sv
module mac16_array #(
    parameter int ACT_W = 8,
    parameter int WGT_W = 8,
    parameter int LANES = 4,
    parameter int ACC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_i,
    input  logic                     clr_i,
    input  logic [ACT_W-1:0]         act_i,
    input  logic [LANES*WGT_W-1:0]   wgt_i,
    output logic                     out_valid_o,
    output logic [LANES*ACC_W-1:0]   acc_o
);
    localparam int MULT_W = ACT_W + 4;

    typedef struct packed {
        logic s1_valid;
        logic out_valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [MULT_W-1:0] m1, m3, m5, m7;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.s1_valid  = in_valid_i;
        ctl_d.out_valid = ctl_q.s1_valid & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mac16_precompute #(.ACT_W(ACT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(in_valid_i),
        .act_i (act_i),
        .m1_o  (m1),
        .m3_o  (m3),
        .m5_o  (m5),
        .m7_o  (m7)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        mac16_lane #(.ACT_W(ACT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (in_valid_i),
            .wgt_i  (wgt_i[l*WGT_W +: WGT_W]),
            .valid_i(ctl_q.s1_valid),
            .clr_i  (clr_i),
            .m1_i   (m1),
            .m3_i   (m3),
            .m5_i   (m5),
            .m7_i   (m7),
            .acc_o  (acc_o[l*ACC_W +: ACC_W])
        );
    end

    assign out_valid_o = ctl_q.out_valid;

    // R6: every valid pulse traces back to a beat two edges earlier
    a_r6_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i, 2));

    // R7: a clear suppresses the pulse of the product it drops
    a_r7_clear_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !out_valid_o);

endmodule

// File: tb/tb_mac16_array.sv
module tb_mac16_array;
    localparam int LANES = 4;
    localparam int AW    = 8;
    localparam int WW    = 8;
    localparam int CW    = 24;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  clr = 1'b0;
    logic [AW-1:0]         act = '0;
    logic [LANES*WW-1:0]   wgt = '0;
    logic                  out_valid;
    logic [LANES*CW-1:0]   acc;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [CW-1:0] exp_acc [LANES];
    logic [CW-1:0] s1_prod [LANES];
    logic          s1_v   = 1'b0;
    logic          exp_ov = 1'b0;

    always #2 clk = ~clk;

    mac16_array #(.ACT_W(AW), .WGT_W(WW), .LANES(LANES), .ACC_W(CW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .clr_i      (clr),
        .act_i      (act),
        .wgt_i      (wgt),
        .out_valid_o(out_valid),
        .acc_o      (acc)
    );

    task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] want);
        checks++;
        if (got !== want) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, $signed(got), $signed(want));
        end
    endtask

    // One clock: drive at negedge, model the two-edge pipeline, compare at next negedge.
    task automatic cycle(input logic v, input logic [AW-1:0] a,
                         input logic [LANES*WW-1:0] w, input logic c, input string req);
        in_valid = v; act = a; wgt = w; clr = c;
        @(posedge clk);
        for (int l = 0; l < LANES; l++) begin
            if (c)         exp_acc[l] = '0;
            else if (s1_v) exp_acc[l] = exp_acc[l] + s1_prod[l];
        end
        exp_ov = s1_v && !c;
        s1_v   = v;
        if (v) begin
            for (int l = 0; l < LANES; l++) begin
                int p;
                p = int'($signed(a)) * int'($signed(w[l*WW +: WW]));
                s1_prod[l] = CW'(p);
            end
        end
        @(negedge clk);
        for (int l = 0; l < LANES; l++) check(req, acc[l*CW +: CW], exp_acc[l]);
        check(req, CW'(out_valid), CW'(exp_ov));
    endtask

    function automatic logic [LANES*WW-1:0] pack4(input int w0, input int w1,
                                                  input int w2, input int w3);
        return {WW'(w3), WW'(w2), WW'(w1), WW'(w0)};
    endfunction

    task automatic test_reset();
        for (int l = 0; l < LANES; l++) begin exp_acc[l] = '0; s1_prod[l] = '0; end
        repeat (3) @(negedge clk);
        for (int l = 0; l < LANES; l++) check("R1 during reset", acc[l*CW +: CW], '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) check("R1 after release", acc[l*CW +: CW], '0);
        check("R1 valid low", CW'(out_valid), '0);
    endtask

    task automatic test_corners();
        cycle(1'b0, '0, '0, 1'b1, "R7");
        cycle(1'b1, 8'h80, pack4(-128, 127, 0, -1), 1'b0, "R3");
        cycle(1'b0, '0, '0, 1'b0, "R3");
        check("R3 -128x-128", acc[0*CW +: CW], CW'(16384));
        check("R3 -128x127",  acc[1*CW +: CW], CW'(-16256));
        check("R10 zero weight", acc[2*CW +: CW], CW'(0));
        check("R3 -128x-1",   acc[3*CW +: CW], CW'(128));
        cycle(1'b0, '0, '0, 1'b1, "R7");
        cycle(1'b1, 8'd127, pack4(-128, 127, 0, 1), 1'b0, "R3");
        cycle(1'b1, 8'd0, pack4(-128, 127, -1, 55), 1'b0, "R10");
        cycle(1'b0, '0, '0, 1'b0, "R10");
        check("R3 127x-128", acc[0*CW +: CW], CW'(-16256));
        check("R3 127x127",  acc[1*CW +: CW], CW'(16129));
        check("R10 zero activation", acc[2*CW +: CW], CW'(0));
        check("R10 zero activation", acc[3*CW +: CW], CW'(127));
    endtask

    task automatic test_latency();
        cycle(1'b0, '0, '0, 1'b1, "R7");
        cycle(1'b1, 8'd5, pack4(3, -7, 9, -2), 1'b0, "R6");
        check("R6 not yet visible", acc[0*CW +: CW], '0);
        check("R6 no pulse yet", CW'(out_valid), '0);
        cycle(1'b0, '0, '0, 1'b0, "R6");
        check("R6 visible", acc[0*CW +: CW], CW'(15));
        check("R6 pulse", CW'(out_valid), CW'(1));
        cycle(1'b0, '0, '0, 1'b0, "R6");
        check("R6 single pulse", CW'(out_valid), '0);
    endtask

    task automatic test_accumulate();
        cycle(1'b0, '0, '0, 1'b1, "R7");
        for (int i = 0; i < 20; i++)
            cycle(1'b1, AW'(i * 13 - 90), pack4(i - 10, 3 * i, -i, 100 - 7 * i), 1'b0, "R5");
        cycle(1'b0, '0, '0, 1'b0, "R5");
        cycle(1'b0, '0, '0, 1'b0, "R5");
    endtask

    task automatic test_idle();
        logic [CW-1:0] held;
        cycle(1'b1, 8'd9, pack4(9, 9, 9, 9), 1'b0, "R8");
        cycle(1'b0, '0, '0, 1'b0, "R8");
        held = acc[0*CW +: CW];
        for (int i = 0; i < 6; i++)
            cycle(1'b0, AW'(i * 37 + 1), pack4(-128, 127, i, -i), 1'b0, "R8");
        check("R8 junk ignored", acc[0*CW +: CW], held);
    endtask

    task automatic test_clear_collision();
        cycle(1'b1, 8'd100, pack4(100, -100, 1, 2), 1'b0, "R7");
        cycle(1'b0, '0, '0, 1'b1, "R7");
        check("R7 product dropped", acc[0*CW +: CW], '0);
        check("R7 no pulse", CW'(out_valid), '0);
        cycle(1'b0, '0, '0, 1'b0, "R7");
        check("R7 stays zero", acc[1*CW +: CW], '0);
    endtask

    task automatic test_wrap();
        cycle(1'b0, '0, '0, 1'b1, "R9");
        for (int i = 0; i < 520; i++)
            cycle(1'b1, 8'h80, pack4(-128, -128, 127, 1), 1'b0, "R9");
        cycle(1'b0, '0, '0, 1'b0, "R9");
        check("R9 wrapped", acc[0*CW +: CW], CW'(-8257536));
    endtask

    task automatic test_sweep();
        cycle(1'b0, '0, '0, 1'b1, "R7");
        for (int a = 0; a < 256; a++)
            for (int g = 0; g < 64; g++)
                cycle(1'b1, AW'(a), pack4(4*g, 4*g + 1, 4*g + 2, 4*g + 3), 1'b0, "R2 R4");
        cycle(1'b0, '0, '0, 1'b0, "R4");
        cycle(1'b0, '0, '0, 1'b0, "R4");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_corners();
        test_latency();
        test_accumulate();
        test_idle();
        test_clear_collision();
        test_wrap();
        test_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule